// File: doc/BRIEF.md
# Vector Load/Store Address Generator

This block produces the per-element effective addresses for a vectorised load or store that is encoded with ordinary scalar load/store fields. A single start pulse captures a base address, a signed 16-bit displacement, an access-width code, an addressing mode, a sign-extension select, a unit-multiplier select and a vector length. The block then steps an element counter from 0 to VL-1. It presents one 64-bit address per cycle on a valid/ready interface and flags the final element.

There are three addressing modes, and each builds its stride from a scalar field. Unit-strided mode multiplies the element number by the access width in bytes. Element-strided mode multiplies it by the displacement. Indexed mode adds a per-element offset operand, which the downstream side supplies live on `idx_off_i` for the element shown on `elem_o`. If the multiplier is forced to one and VL is 1, the result is exactly the scalar base-plus-displacement address. The block only reads its captured base and never returns an updated base to anything.

Top module: `vls_agen`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `busy_o` are low.
- R2: `start_i` is accepted only while `busy_o` is low. The cycle after acceptance, `valid_o` and `busy_o` are high and `elem_o` is 0.
- R3: Unit-strided mode (`mode_i` 2'b00, and the reserved code 2'b11 behaves the same) gives address = base + sext(disp) + elem × bytes. Bytes is 1, 2, 4 or 8 for `width_i` 0, 1, 2 or 3.
- R4: When `unit_one_i` is set, the unit-strided multiplier is 1, giving address = base + sext(disp) + elem. Element 0 is therefore the plain scalar address.
- R5: Element-strided mode (`mode_i` 2'b01) gives address = base + sext(disp) × elem, where disp is a 16-bit two's-complement value.
- R6: Indexed mode (`mode_i` 2'b10) gives address = base + ext(off). Here off is the low 8, 16 or 32 bits of `idx_off_i` for `width_i` 0, 1 or 2, or all 64 bits for `width_i` 3. It is sign-extended when `idx_signed_i` is 1 and zero-extended otherwise.
- R7: `idx_signed_i` has no effect on the address in unit-strided or element-strided mode.
- R8: All address arithmetic wraps modulo 2^64. No overflow indication exists.
- R9: While `valid_o` is high and `ready_i` is low, `elem_o` holds. Each cycle with `valid_o` and `ready_i` high advances `elem_o` by one.
- R10: `last_o` is high only with element VL-1, and `valid_o` is low the cycle after that element is taken. A `vl_i` of 0 is treated as 1, and values above 64 are treated as 64.
- R11: Configuration inputs and `start_i` presented while `busy_o` is high do not affect the addresses of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a run (taken while idle) |
| mode_i | input | 2 | 00 unit-strided, 01 element-strided, 10 indexed, 11 as 00 |
| width_i | input | 2 | Access width code: bytes = 1 << code |
| unit_one_i | input | 1 | Force unit-strided multiplier to 1 |
| idx_signed_i | input | 1 | Sign-extend indexed offset when 1 |
| vl_i | input | 7 | Vector length, 1 to 64 |
| base_i | input | 64 | Base register value |
| disp_i | input | 16 | Signed displacement |
| idx_off_i | input | 64 | Offset operand for the element on `elem_o` |
| ready_i | input | 1 | Downstream accepts the current address |
| valid_o | output | 1 | Address valid |
| addr_o | output | 64 | Effective address |
| elem_o | output | 6 | Current element number |
| last_o | output | 1 | Current element is VL-1 |
| busy_o | output | 1 | A run is in progress |

## Verification
Every cycle, the assertions check the handshake sequencing: the element holds on a stall, advances by one when taken, starts at zero, and valid drops after the last element. They also check the stride between consecutive addresses in unit-strided and element-strided modes, taken against the width and displacement captured at start. The bench scenarios are needed for the absolute address values. These include the indexed extension at each width and sign setting, wrap-around past 2^64, the VL clamping at both ends, and the proof that configuration changes during a run are ignored.

// File: rtl/vls_agen_pkg.sv
package vls_agen_pkg;

    typedef enum logic [1:0] {
        MODE_UNIT  = 2'b00,
        MODE_ELEM  = 2'b01,
        MODE_INDEX = 2'b10,
        MODE_RSVD  = 2'b11
    } agen_mode_e;

    localparam int WCODE_W = 2;

endpackage

// File: rtl/vls_agen_ext.sv
module vls_agen_ext #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0]                 raw_i,
    input  logic [vls_agen_pkg::WCODE_W-1:0]  wcode_i,
    input  logic                              is_signed_i,
    output logic [ADDR_W-1:0]                 ext_o
);
    localparam int NARROW = 3;

    logic [ADDR_W-1:0] lane_ext [NARROW];

    for (genvar g = 0; g < NARROW; g++) begin : g_lane
        localparam int LW = 8 << g;
        logic fill;
        assign fill = is_signed_i & raw_i[LW-1];
        assign lane_ext[g] = {{(ADDR_W-LW){fill}}, raw_i[LW-1:0]};
    end

    always_comb begin
        case (wcode_i)
            2'd0:    ext_o = lane_ext[0];
            2'd1:    ext_o = lane_ext[1];
            2'd2:    ext_o = lane_ext[2];
            default: ext_o = raw_i;
        endcase
    end
endmodule

// File: rtl/vls_agen_calc.sv
module vls_agen_calc #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16,
    parameter int IDX_W  = 6
) (
    input  vls_agen_pkg::agen_mode_e          mode_i,
    input  logic [vls_agen_pkg::WCODE_W-1:0]  wcode_i,
    input  logic                              unit_one_i,
    input  logic [ADDR_W-1:0]                 base_i,
    input  logic [DISP_W-1:0]                 disp_i,
    input  logic [IDX_W-1:0]                  idx_i,
    input  logic [ADDR_W-1:0]                 ext_off_i,
    output logic [ADDR_W-1:0]                 addr_o
);
    import vls_agen_pkg::*;

    logic [ADDR_W-1:0] disp_x;
    logic [ADDR_W-1:0] idx_x;
    logic [ADDR_W-1:0] unit_step;
    logic [ADDR_W-1:0] elem_step;

    assign disp_x    = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    assign idx_x     = {{(ADDR_W-IDX_W){1'b0}}, idx_i};
    assign unit_step = unit_one_i ? idx_x : (idx_x << wcode_i);
    assign elem_step = disp_x * idx_x;

    always_comb begin
        case (mode_i)
            MODE_ELEM:  addr_o = base_i + elem_step;
            MODE_INDEX: addr_o = base_i + ext_off_i;
            default:    addr_o = base_i + disp_x + unit_step;
        endcase
    end
endmodule

// File: rtl/vls_agen.sv
module vls_agen #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16,
    parameter int VL_MAX = 64,
    localparam int IDX_W = $clog2(VL_MAX),
    localparam int VL_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        width_i,
    input  logic              unit_one_i,
    input  logic              idx_signed_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [ADDR_W-1:0] idx_off_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [IDX_W-1:0]  elem_o,
    output logic              last_o,
    output logic              busy_o
);
    import vls_agen_pkg::*;

    typedef struct packed {
        logic               active;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   last_idx;
        agen_mode_e         mode;
        logic [WCODE_W-1:0] wcode;
        logic               unit_one;
        logic               idx_signed;
        logic [ADDR_W-1:0]  base;
        logic [DISP_W-1:0]  disp;
    } agen_state_t;

    agen_state_t st_d, st_q;
    logic [VL_W-1:0]  vl_eff;
    logic             at_end;

    // Clamp the requested length into 1..VL_MAX.
    always_comb begin
        if (vl_i == '0)
            vl_eff = VL_W'(1);
        else if (vl_i > VL_W'(VL_MAX))
            vl_eff = VL_W'(VL_MAX);
        else
            vl_eff = vl_i;
    end

    assign at_end = (st_q.idx == st_q.last_idx);

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (start_i) begin
                st_d.active     = 1'b1;
                st_d.idx        = '0;
                st_d.last_idx   = IDX_W'(vl_eff - VL_W'(1));
                st_d.mode       = agen_mode_e'(mode_i);
                st_d.wcode      = width_i;
                st_d.unit_one   = unit_one_i;
                st_d.idx_signed = idx_signed_i;
                st_d.base       = base_i;
                st_d.disp       = disp_i;
            end
        end else if (ready_i) begin
            if (at_end)
                st_d.active = 1'b0;
            else
                st_d.idx = st_q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    logic [ADDR_W-1:0] ext_off;

    vls_agen_ext #(.ADDR_W(ADDR_W)) u_ext (
        .raw_i       (idx_off_i),
        .wcode_i     (st_q.wcode),
        .is_signed_i (st_q.idx_signed),
        .ext_o       (ext_off)
    );

    vls_agen_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .IDX_W(IDX_W)) u_calc (
        .mode_i     (st_q.mode),
        .wcode_i    (st_q.wcode),
        .unit_one_i (st_q.unit_one),
        .base_i     (st_q.base),
        .disp_i     (st_q.disp),
        .idx_i      (st_q.idx),
        .ext_off_i  (ext_off),
        .addr_o     (addr_o)
    );

    // Captured configuration, brought out for the bound checker.
    logic [1:0]        mode_q;
    logic [1:0]        wcode_q;
    logic              unit_one_q;
    logic [DISP_W-1:0] disp_q;

    assign mode_q     = st_q.mode;
    assign wcode_q    = st_q.wcode;
    assign unit_one_q = st_q.unit_one;
    assign disp_q     = st_q.disp;

    assign valid_o = st_q.active;
    assign busy_o  = st_q.active;
    assign elem_o  = st_q.idx;
    assign last_o  = st_q.active & at_end;
endmodule

// File: rtl/vls_agen_chk.sv
module vls_agen_chk #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_o,
    input logic              ready_i,
    input logic              last_o,
    input logic [IDX_W-1:0]  elem_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [1:0]        mode_q,
    input logic [1:0]        wcode_q,
    input logic              unit_one_q,
    input logic [DISP_W-1:0] disp_q
);
    logic [ADDR_W-1:0] disp_x;
    logic              unit_like;
    assign disp_x    = {{(ADDR_W-DISP_W){disp_q[DISP_W-1]}}, disp_q};
    assign unit_like = (mode_q == 2'b00) || (mode_q == 2'b11);

    a_r2_first_elem_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> elem_o == '0);

    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o && elem_o == $past(elem_o));

    a_r9_advance_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && ready_i && !last_o |=> valid_o && elem_o == $past(elem_o) + IDX_W'(1));

    a_r10_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && ready_i && last_o |=> !valid_o);

    a_r10_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    a_r3_unit_stride: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && ready_i && !last_o && unit_like && !unit_one_q
        |=> addr_o == $past(addr_o) + (ADDR_W'(1) << $past(wcode_q)));

    a_r4_unit_one_stride: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && ready_i && !last_o && unit_like && unit_one_q
        |=> addr_o == $past(addr_o) + ADDR_W'(1));

    a_r5_elem_stride: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && ready_i && !last_o && mode_q == 2'b01
        |=> addr_o == $past(addr_o) + $past(disp_x));
endmodule

bind vls_agen vls_agen_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_o    (valid_o),
    .ready_i    (ready_i),
    .last_o     (last_o),
    .elem_o     (elem_o),
    .addr_o     (addr_o),
    .mode_q     (mode_q),
    .wcode_q    (wcode_q),
    .unit_one_q (unit_one_q),
    .disp_q     (disp_q)
);

// File: tb/vls_agen_bench.sv
`timescale 1ns/1ps
module vls_agen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [1:0]  width_i = '0;
    logic        unit_one_i = 1'b0;
    logic        idx_signed_i = 1'b0;
    logic [6:0]  vl_i = '0;
    logic [63:0] base_i = '0;
    logic [15:0] disp_i = '0;
    logic [63:0] idx_off_i = '0;
    logic        ready_i = 1'b0;
    logic        valid_o;
    logic [63:0] addr_o;
    logic [5:0]  elem_o;
    logic        last_o;
    logic        busy_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    vls_agen u_vls_agen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .width_i(width_i), .unit_one_i(unit_one_i), .idx_signed_i(idx_signed_i),
        .vl_i(vl_i), .base_i(base_i), .disp_i(disp_i), .idx_off_i(idx_off_i),
        .ready_i(ready_i), .valid_o(valid_o), .addr_o(addr_o), .elem_o(elem_o),
        .last_o(last_o), .busy_o(busy_o)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  w;
        logic        one;
        logic        sgn;
        logic [6:0]  vl;
        logic        stall;
        logic [63:0] base;
        logic [15:0] disp;
        logic [63:0] seed;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 2'd3, 1'b0, 1'b0, 7'd4, 1'b0, 64'h1000, 16'h0010, 64'h0, 8'd3},
        '{2'b00, 2'd0, 1'b0, 1'b1, 7'd3, 1'b1, 64'h2000, 16'hFFFC, 64'h0, 8'd7},
        '{2'b11, 2'd1, 1'b0, 1'b0, 7'd3, 1'b0, 64'h2800, 16'h0002, 64'h0, 8'd3},
        '{2'b00, 2'd3, 1'b1, 1'b0, 7'd3, 1'b0, 64'h3000, 16'h0008, 64'h0, 8'd4},
        '{2'b01, 2'd2, 1'b0, 1'b0, 7'd5, 1'b1, 64'h4000, 16'h0040, 64'h0, 8'd5},
        '{2'b01, 2'd3, 1'b0, 1'b1, 7'd4, 1'b0, 64'h0100, 16'hFFF8, 64'h0, 8'd7},
        '{2'b10, 2'd0, 1'b0, 1'b1, 7'd4, 1'b0, 64'h5000, 16'h0000, 64'h0000_0000_0000_007E, 8'd6},
        '{2'b10, 2'd1, 1'b0, 1'b0, 7'd4, 1'b1, 64'h6000, 16'h0000, 64'h0000_0000_0000_7FF0, 8'd6},
        '{2'b10, 2'd2, 1'b0, 1'b1, 7'd3, 1'b0, 64'h7000, 16'h0000, 64'h1234_5678_7FFF_FFF0, 8'd6},
        '{2'b10, 2'd3, 1'b0, 1'b0, 7'd3, 1'b0, 64'h8000, 16'h0000, 64'hFFFF_FFFF_FFFF_F000, 8'd6},
        '{2'b00, 2'd3, 1'b0, 1'b0, 7'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 16'h0008, 64'h0, 8'd8}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] off_of(input logic [63:0] seed, input int k);
        return seed + 64'(k) * 64'h9E37_79B9_7F4A_7C15;
    endfunction

    function automatic logic [63:0] ext_of(input logic [63:0] off, input logic [1:0] w,
                                           input logic sgn);
        int sh;
        logic [63:0] x;
        sh = 64 - (8 << w);
        x = off << sh;
        if (sgn) return 64'($signed(x) >>> sh);
        return x >> sh;
    endfunction

    function automatic logic [63:0] exp_addr(input vec_t v, input int k,
                                             input logic [63:0] off);
        logic [63:0] dx;
        dx = {{48{v.disp[15]}}, v.disp};
        case (v.mode)
            2'b01:   return v.base + dx * 64'(k);
            2'b10:   return v.base + ext_of(off, v.w, v.sgn);
            default: return v.base + dx + (v.one ? 64'(k) : (64'(k) << v.w));
        endcase
    endfunction

    function automatic string rtag(input logic [7:0] r);
        case (r)
            8'd3: return "R3";
            8'd4: return "R4";
            8'd5: return "R5";
            8'd6: return "R6";
            8'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic start_run(input vec_t v);
        @(negedge clk);
        mode_i = v.mode; width_i = v.w; unit_one_i = v.one; idx_signed_i = v.sgn;
        vl_i = v.vl; base_i = v.base; disp_i = v.disp; start_i = 1'b1; ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check(valid_o && busy_o && elem_o == 6'd0, "R2",
              {valid_o, busy_o, 56'd0, elem_o}, 64'h3 << 62);
    endtask

    task automatic walk(input vec_t v, input int n);
        for (int k = 0; k < n; k++) begin
            idx_off_i = off_of(v.seed, k);
            if (v.stall) begin
                ready_i = 1'b0;
                #1;
                check(valid_o && elem_o == 6'(k), "R9", 64'(elem_o), 64'(k));
                @(negedge clk);
                #1;
                check(valid_o && elem_o == 6'(k), "R9", 64'(elem_o), 64'(k));
            end
            ready_i = 1'b1;
            #1;
            check(addr_o == exp_addr(v, k, idx_off_i), rtag(v.req), addr_o,
                  exp_addr(v, k, idx_off_i));
            check(last_o == (k == n - 1), "R10", 64'(last_o), 64'(k == n - 1));
            @(negedge clk);
        end
        ready_i = 1'b0;
        #1;
        check(!valid_o && !busy_o, "R10", 64'(valid_o), 64'd0);
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        #1;
        check(!valid_o && !last_o && !busy_o, "R1", {61'd0, valid_o, last_o, busy_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!valid_o && !busy_o, "R1", {62'd0, valid_o, busy_o}, 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            start_run(VECS[i]);
            walk(VECS[i], int'(VECS[i].vl));
        end

        // R7: same element-strided run with sign select flipped gives identical addresses
        v = VECS[4];
        v.sgn = 1'b1; v.stall = 1'b0; v.req = 8'd7;
        start_run(v);
        walk(v, 5);

        // R10: length 0 behaves as 1
        v = VECS[0];
        v.vl = 7'd0;
        start_run(v);
        walk(v, 1);

        // R10: length above the maximum is clamped to 64
        v = VECS[2];
        v.vl = 7'd100;
        start_run(v);
        walk(v, 64);

        // R11: a new start and configuration during a run are ignored
        v = VECS[0];
        start_run(v);
        idx_off_i = '0;
        ready_i = 1'b1;
        #1;
        check(addr_o == exp_addr(v, 0, 64'd0), "R11", addr_o, exp_addr(v, 0, 64'd0));
        start_i = 1'b1; base_i = 64'hDEAD_0000; disp_i = 16'h0100;
        mode_i = 2'b01; width_i = 2'd0; vl_i = 7'd9;
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            if (k == 3) start_i = 1'b0;
            #1;
            check(addr_o == exp_addr(v, k, 64'd0) && elem_o == 6'(k), "R11", addr_o,
                  exp_addr(v, k, 64'd0));
        end
        check(last_o, "R11", 64'(last_o), 64'd1);
        @(negedge clk);
        ready_i = 1'b0;
        #1;
        check(!valid_o, "R11", 64'(valid_o), 64'd0);

        // R2: a start while idle is taken
        v = VECS[3];
        start_run(v);
        walk(v, 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule